// File: doc/BRIEF.md
# Night Frame Background Fusion

This streaming pixel block takes two inputs in lockstep. One is a colour night-time pixel stream, the other a grey-scale daytime picture of the same scene, pixel for pixel. Each night pixel is reduced to a grey value. A programmable dark level is removed from that value, and the remainder is compared with a programmable threshold. Pixels above the threshold count as scene objects and keep their night grey value. Every other position takes the daytime pixel. The output stream therefore shows the night objects set on a daylit background, and it carries a per-pixel foreground flag.

The two inputs use valid/ready handshakes and advance together: a pair is consumed only when both sides offer a beat. Start-of-frame and end-of-line markers come with each beat. If the markers of a consumed pair disagree, the output beat carries an alignment-error flag. The pipeline holds three registers and obeys backpressure from the output.

Top module: `night_bg_fuse`

## Requirements
- R1: Night pixels arrive as 24 bits with red in [23:16], green in [15:8] and blue in [7:0]. The grey value is (77*R + 150*G + 29*B) >> 8.
- R2: The dark level is subtracted from the grey value and the result is clamped at zero. A grey value below the dark level is never foreground.
- R3: A pixel is foreground (out_fg = 1) only when the clamped difference is strictly greater than the threshold. A difference equal to the threshold is background.
- R4: out_pix equals the night grey value for a foreground pixel and the daytime pixel of the same pair otherwise.
- R5: out_sof and out_eol repeat the night-side markers of the pair that produced the beat.
- R6: out_err is 1 exactly when the night and daytime markers of the consumed pair differ in start-of-frame or in end-of-line.
- R7: While the output is not stalled, a pair consumed in cycle n appears on the output in cycle n+3.
- R8: A pair is consumed only when both valids are high. Neither side is ever taken alone (nt_ready low while rf_valid is low, and the reverse).
- R9: While out_valid is high and out_ready is low, every output holds its value. Every consumed pair leaves exactly once, in order.
- R10: During reset and directly after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nt_valid | input | 1 | Night beat valid |
| nt_ready | output | 1 | Night beat accepted when high with nt_valid |
| nt_rgb | input | 24 | Night colour pixel, R/G/B |
| nt_sof | input | 1 | Night start-of-frame marker |
| nt_eol | input | 1 | Night end-of-line marker |
| rf_valid | input | 1 | Daytime beat valid |
| rf_ready | output | 1 | Daytime beat accepted when high with rf_valid |
| rf_pix | input | 8 | Daytime grey pixel |
| rf_sof | input | 1 | Daytime start-of-frame marker |
| rf_eol | input | 1 | Daytime end-of-line marker |
| dark_level | input | 8 | Dark background level to subtract |
| fg_thresh | input | 8 | Foreground threshold |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_pix | output | 8 | Fused pixel |
| out_fg | output | 1 | Foreground flag |
| out_sof | output | 1 | Start-of-frame marker |
| out_eol | output | 1 | End-of-line marker |
| out_err | output | 1 | Marker mismatch on this pair |

## Verification
Corrupted stage state reaches the ports three cycles after the pair enters. It shows up as a wrong fused value, a wrong flag, or marker bits attached to the wrong beat. Bad shared-advance logic shows up sooner: a pair is dropped, duplicated, or drifts by a beat under backpressure, and the next output then disagrees with the in-order model. Threshold and dark-level edge pixels are fed with grey values one step either side of the boundary, so an off-by-one or a wrapping subtraction changes out_fg on that very beat.

// File: rtl/nbf_pkg.sv
// Package: shared types for the night background fusion block.
// Assumes: markers are single bits; the tag travels unchanged down the pipe.
package nbf_pkg;
    typedef struct packed {
        logic sof;
        logic eol;
        logic err;
    } nbf_tag_t;

    localparam int TAG_W = $bits(nbf_tag_t);
endpackage

// File: rtl/nbf_luma.sv
// Module: nbf_luma
// Purpose: weighted RGB to grey conversion, purely combinational.
// Assumes: channels packed R (high) G B (low); result clamps at channel max.
module nbf_luma #(
    parameter int CHAN_W = 8,
    parameter int WR     = 77,
    parameter int WG     = 150,
    parameter int WB     = 29,
    parameter int SHIFT  = 8
) (
    input  logic [3*CHAN_W-1:0] rgb,
    output logic [CHAN_W-1:0]   grey
);
    localparam int SUM_W = CHAN_W + 14;
    localparam logic [CHAN_W-1:0] MAXV = '1;

    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] scaled;

    // Weighted sum, scale down and clamp to channel range.
    always_comb begin
        acc = SUM_W'(rgb[3*CHAN_W-1:2*CHAN_W]) * SUM_W'(WR)
            + SUM_W'(rgb[2*CHAN_W-1:CHAN_W])   * SUM_W'(WG)
            + SUM_W'(rgb[CHAN_W-1:0])          * SUM_W'(WB);
        scaled = acc >> SHIFT;
        grey = (scaled > SUM_W'(MAXV)) ? MAXV : scaled[CHAN_W-1:0];
    end
endmodule

// File: rtl/nbf_fg_detect.sv
// Module: nbf_fg_detect
// Purpose: clamped dark-level removal followed by a strict threshold test.
// Assumes: unsigned pixel values of equal width.
module nbf_fg_detect #(
    parameter int CHAN_W = 8
) (
    input  logic [CHAN_W-1:0] grey,
    input  logic [CHAN_W-1:0] dark,
    input  logic [CHAN_W-1:0] thresh,
    output logic              fg
);
    logic [CHAN_W-1:0] lifted;

    // Subtract the dark level without wrapping, then compare.
    always_comb begin
        lifted = (grey > dark) ? (grey - dark) : '0;
        fg     = lifted > thresh;
    end
endmodule

// File: rtl/nbf_pipe_reg.sv
// Module: nbf_pipe_reg
// Purpose: one pipeline stage with a valid bit, advanced by a shared enable.
// Assumes: en is common to all stages, so a stall freezes the whole pipe.
module nbf_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    // Capture the stage contents when the pipe advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (en) begin
            out_valid <= in_valid;
            out_data  <= in_data;
        end
    end
endmodule

// File: rtl/night_bg_fuse.sv
// Module: night_bg_fuse (top)
// Purpose: replaces the dark night background with a daytime reference
//          and keeps night objects, three register stages deep.
// Assumes: both inputs describe the same pixel position on each consumed
//          pair; dark_level and fg_thresh change only while the pipe is idle.
module night_bg_fuse
    import nbf_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int WR     = 77,
    parameter int WG     = 150,
    parameter int WB     = 29,
    parameter int SHIFT  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nt_valid,
    output logic                nt_ready,
    input  logic [3*CHAN_W-1:0] nt_rgb,
    input  logic                nt_sof,
    input  logic                nt_eol,
    input  logic                rf_valid,
    output logic                rf_ready,
    input  logic [CHAN_W-1:0]   rf_pix,
    input  logic                rf_sof,
    input  logic                rf_eol,
    input  logic [CHAN_W-1:0]   dark_level,
    input  logic [CHAN_W-1:0]   fg_thresh,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [CHAN_W-1:0]   out_pix,
    output logic                out_fg,
    output logic                out_sof,
    output logic                out_eol,
    output logic                out_err
);
    localparam int S1_W = 2*CHAN_W + TAG_W;
    localparam int S2_W = 2*CHAN_W + 1 + TAG_W;
    localparam int S3_W = CHAN_W + 1 + TAG_W;

    logic              advance;
    logic              take;
    logic [CHAN_W-1:0] grey_in;
    nbf_tag_t          tag_in;

    logic              s1_v, s2_v, s3_v;
    logic [S1_W-1:0]   s1_d;
    logic [S2_W-1:0]   s2_d;
    logic [S3_W-1:0]   s3_d;

    logic [CHAN_W-1:0] s1_grey, s1_ref, s2_grey, s2_ref;
    nbf_tag_t          s1_tag, s2_tag, s3_tag;
    logic              s2_fg_in, s2_fg;
    logic [CHAN_W-1:0] fused;

    // Shared advance: the pipe moves unless a held output is refused.
    always_comb begin
        advance  = !s3_v || out_ready;
        take     = advance && nt_valid && rf_valid;
        nt_ready = advance && rf_valid;
        rf_ready = advance && nt_valid;
    end

    nbf_luma #(.CHAN_W(CHAN_W), .WR(WR), .WG(WG), .WB(WB), .SHIFT(SHIFT)) u_luma (
        .rgb  (nt_rgb),
        .grey (grey_in)
    );

    // Marker bookkeeping for the pair entering the pipe.
    always_comb begin
        tag_in.sof = nt_sof;
        tag_in.eol = nt_eol;
        tag_in.err = (nt_sof != rf_sof) || (nt_eol != rf_eol);
    end

    nbf_pipe_reg #(.W(S1_W)) u_s1 (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .in_valid(take), .in_data({grey_in, rf_pix, tag_in}),
        .out_valid(s1_v), .out_data(s1_d)
    );

    // Unpack stage one.
    always_comb begin
        {s1_grey, s1_ref, s1_tag} = s1_d;
    end

    nbf_fg_detect #(.CHAN_W(CHAN_W)) u_det (
        .grey   (s1_grey),
        .dark   (dark_level),
        .thresh (fg_thresh),
        .fg     (s2_fg_in)
    );

    nbf_pipe_reg #(.W(S2_W)) u_s2 (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .in_valid(s1_v), .in_data({s1_grey, s1_ref, s2_fg_in, s1_tag}),
        .out_valid(s2_v), .out_data(s2_d)
    );

    // Unpack stage two and choose the fused pixel.
    always_comb begin
        {s2_grey, s2_ref, s2_fg, s2_tag} = s2_d;
        fused = s2_fg ? s2_grey : s2_ref;
    end

    nbf_pipe_reg #(.W(S3_W)) u_s3 (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .in_valid(s2_v), .in_data({fused, s2_fg, s2_tag}),
        .out_valid(s3_v), .out_data(s3_d)
    );

    // Drive the output port from stage three.
    always_comb begin
        {out_pix, out_fg, s3_tag} = s3_d;
        out_valid = s3_v;
        out_sof   = s3_tag.sof;
        out_eol   = s3_tag.eol;
        out_err   = s3_tag.err;
    end
endmodule

// File: rtl/nbf_chk.sv
// Module: nbf_chk
// Purpose: protocol and flag properties of night_bg_fuse, bound to the top.
// Assumes: thresholds are stable while beats are in flight.
module nbf_chk #(
    parameter int CHAN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nt_valid,
    input logic              nt_ready,
    input logic              rf_valid,
    input logic              rf_ready,
    input logic [CHAN_W-1:0] fg_thresh,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CHAN_W-1:0] out_pix,
    input logic              out_fg,
    input logic              out_sof,
    input logic              out_eol,
    input logic              out_err
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_fg)
            && $stable(out_sof) && $stable(out_eol) && $stable(out_err)));

    // R3
    fg_above_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fg) |-> (out_pix > fg_thresh));

    // R8
    night_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_valid && nt_ready) |-> rf_valid);

    // R8
    ref_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && rf_ready) |-> nt_valid);
endmodule

bind night_bg_fuse nbf_chk #(.CHAN_W(CHAN_W)) u_nbf_chk (
    .clk(clk), .rst_n(rst_n),
    .nt_valid(nt_valid), .nt_ready(nt_ready),
    .rf_valid(rf_valid), .rf_ready(rf_ready),
    .fg_thresh(fg_thresh),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_fg(out_fg),
    .out_sof(out_sof), .out_eol(out_eol), .out_err(out_err)
);

// File: tb/night_bg_fuse_bench.sv
// Bench: behavioural queue model of night_bg_fuse, compared every cycle.
module night_bg_fuse_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nt_valid = 1'b0, nt_sof = 1'b0, nt_eol = 1'b0;
    logic [23:0] nt_rgb = '0;
    logic        rf_valid = 1'b0, rf_sof = 1'b0, rf_eol = 1'b0;
    logic [7:0]  rf_pix = '0;
    logic [7:0]  dark_level = 8'd0, fg_thresh = 8'd0;
    logic        out_ready = 1'b1;
    logic        nt_ready, rf_ready, out_valid, out_fg, out_sof, out_eol, out_err;
    logic [7:0]  out_pix;

    typedef struct {
        int pix; bit fg; bit err; bit sof; bit eol; int cyc; bit lat;
    } exp_t;
    exp_t q[$];

    int  checks = 0, errors = 0, cyc = 0;
    bit  bp_mode = 0, lat_mode = 0, done = 0;

    night_bg_fuse u_night_bg_fuse (
        .clk(clk), .rst_n(rst_n),
        .nt_valid(nt_valid), .nt_ready(nt_ready), .nt_rgb(nt_rgb),
        .nt_sof(nt_sof), .nt_eol(nt_eol),
        .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_pix(rf_pix),
        .rf_sof(rf_sof), .rf_eol(rf_eol),
        .dark_level(dark_level), .fg_thresh(fg_thresh),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_fg(out_fg), .out_sof(out_sof), .out_eol(out_eol), .out_err(out_err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Reference model of one consumed pair.
    function automatic exp_t model(input logic [23:0] rgb, input logic [7:0] rp,
                                   input bit ns, input bit ne, input bit rs, input bit re);
        exp_t e;
        int g, d;
        g = (77*rgb[23:16] + 150*rgb[15:8] + 29*rgb[7:0]) / 256;
        d = (g > dark_level) ? g - dark_level : 0;
        e.fg  = d > fg_thresh;
        e.pix = e.fg ? g : rp;
        e.err = (ns != rs) || (ne != re);
        e.sof = ns;
        e.eol = ne;
        e.cyc = cyc;
        e.lat = lat_mode;
        return e;
    endfunction

    // Monitor at the falling edge, when all signals are settled.
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (!rst_n) begin
            check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
        end else begin
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(0, "R9 extra output beat", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(out_pix == e.pix, "R1 R4 out_pix", out_pix, e.pix);
                    check(out_fg == e.fg, "R2 R3 out_fg", out_fg, e.fg);
                    check(out_err == e.err, "R6 out_err", out_err, e.err);
                    check(out_sof == e.sof && out_eol == e.eol, "R5 markers",
                          {out_sof, out_eol}, {e.sof, e.eol});
                    if (e.lat)
                        check(cyc - e.cyc == 3, "R7 latency", cyc - e.cyc, 3);
                end
            end
            if (nt_valid && nt_ready && rf_valid && rf_ready)
                q.push_back(model(nt_rgb, rf_pix, nt_sof, nt_eol, rf_sof, rf_eol));
        end
    end

    // Output backpressure pattern.
    always @(posedge clk) begin
        #2;
        out_ready <= bp_mode ? ($urandom % 3 != 0) : 1'b1;
    end

    task automatic send(input logic [23:0] rgb, input logic [7:0] rp,
                        input bit ns, input bit ne, input bit rs, input bit re);
        nt_rgb = rgb; rf_pix = rp;
        nt_sof = ns; nt_eol = ne; rf_sof = rs; rf_eol = re;
        nt_valid = 1'b1; rf_valid = 1'b1;
        @(negedge clk);
        while (!nt_ready) @(negedge clk);
        @(posedge clk); #2;
        nt_valid = 1'b0; rf_valid = 1'b0;
    endtask

    function automatic logic [23:0] grey_rgb(input int v);
        return {v[7:0], v[7:0], v[7:0]};
    endfunction

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9 all beats delivered", q.size(), 0);
    endtask

    task automatic send_frame(input int w, input int h);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                send(24'($urandom), 8'($urandom), (x == 0 && y == 0), (x == w-1),
                     (x == 0 && y == 0), (x == w-1));
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);

        // R2 R3: threshold boundary, grey = dark + thresh is background.
        lat_mode = 1;
        dark_level = 8'd40; fg_thresh = 8'd20;
        send(grey_rgb(60), 8'd200, 1, 0, 1, 0);
        send(grey_rgb(61), 8'd201, 0, 0, 0, 0);
        send(grey_rgb(255), 8'd7, 0, 0, 0, 0);
        send(grey_rgb(0), 8'd9, 0, 1, 0, 1);
        // R1: pure channels.
        send(24'hFF0000, 8'd1, 0, 0, 0, 0);
        send(24'h00FF00, 8'd2, 0, 0, 0, 0);
        send(24'h0000FF, 8'd3, 0, 0, 0, 0);
        drain();

        // R2: below the dark level must not wrap into foreground.
        dark_level = 8'd40; fg_thresh = 8'd0;
        send(grey_rgb(10), 8'd55, 1, 0, 1, 0);
        send(grey_rgb(40), 8'd56, 0, 0, 0, 0);
        send(grey_rgb(41), 8'd57, 0, 1, 0, 1);
        drain();

        // R6: marker mismatches on either field.
        send(grey_rgb(100), 8'd3, 1, 0, 0, 0);
        send(grey_rgb(100), 8'd3, 0, 1, 0, 0);
        send(grey_rgb(100), 8'd3, 0, 0, 0, 0);
        drain();

        // R8: night side alone is not taken.
        nt_rgb = grey_rgb(90); rf_pix = 8'd4;
        nt_sof = 0; nt_eol = 0; rf_sof = 0; rf_eol = 0;
        nt_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(nt_ready == 1'b0, "R8 nt_ready without ref", nt_ready, 0);
        end
        rf_valid = 1'b1;
        @(negedge clk);
        while (!nt_ready) @(negedge clk);
        @(posedge clk); #2;
        nt_valid = 1'b0; rf_valid = 1'b0;
        drain();

        // Random frames, free-flowing then under backpressure (R7, R9).
        dark_level = 8'd30; fg_thresh = 8'd50;
        send_frame(6, 3);
        drain();
        lat_mode = 0; bp_mode = 1;
        dark_level = 8'd80; fg_thresh = 8'd10;
        send_frame(8, 4);
        drain();
        bp_mode = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 no stray beat", out_valid, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule